// File: doc/BRIEF.md
# Input-Port Change-of-State Detector

This block watches three general-purpose input pins and reports, through one
CPU-readable status byte, the filtered level of each pin together with a sticky
change-of-state flag per pin. A pin's new level is only believed once it has
been seen on two consecutive ticks of a slow, internally divided sample strobe.
With the default divider at a 125 MHz clock, a level that lasts under 25 µs is
discarded and one that lasts 50 µs or more is always taken.

Some pins may serve as active-low clear-to-send handshake lines, marked by a
parameter mask. Tracking starts a fixed number of serial-clock strobes after
reset. At that moment the filter is loaded with the synchronized pins. Any
handshake pin found low then raises its flag with no transition needed.

Reading the status byte clears all flags. A write-only enable field picks which
flags may drive a registered, active-high interrupt. A summary bit, the OR of
all flags, goes to the chip's interrupt status register.

Top module: `ipcos_monitor`

## Requirements
- R1: Status byte layout: bits [2:0] are the pin levels, bits [6:4] are the change flags of pins 2..0, and bits 7 and 3 always read 0.
- R2: A new pin level is accepted only after it has been sampled on two consecutive sample strobes. A pulse shorter than one strobe period never sets a flag. A level held for two strobe periods or more always sets it.
- R3: Accepted transitions in either direction, low-to-high or high-to-low, set the pin's flag.
- R4: Until the second serial-clock strobe after reset, the level bits read 1 and all flags read 0. After that strobe, the level bits follow the filtered pins.
- R5: At the start-up strobe, a pin marked as clear-to-send (CTS_MASK bit = 1) that is low sets its flag. A low pin that is not marked does not set its flag.
- R6: A read strobe clears every flag from the next cycle. The summary output is 1 exactly when at least one flag is set.
- R7: If a flag is set in the same cycle as a read strobe, the flag stays set after that cycle.
- R8: Enable bits reset to 0 and are loaded from wr_data on a write strobe. irq is 1 one cycle after some flag and its enable are both 1, and 0 one cycle after none are.
- R9: A level bit reads 1 when its pin is high (handshake negated) and 0 when it is low (handshake asserted).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_tick | input | 1 | One-cycle strobe per serial-clock period |
| pins_i | input | 3 | Asynchronous input pins |
| rd_stb | input | 1 | Status read strobe; clears the flags |
| wr_stb | input | 1 | Enable-field write strobe |
| wr_data | input | 3 | Enable bits to be written |
| status_o | output | 8 | Status byte (levels, flags, zeros) |
| cos_any_o | output | 1 | Summary change flag for the interrupt status register |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The assertions take for granted that ser_tick, rd_stb and wr_stb are single-cycle strobes sampled on the rising edge. The pins may change at any time, because each one passes through a synchronizer before any checked state. The bench drives every input on the falling edge and keeps ser_tick a one-cycle pulse every fourth cycle. It shortens the sample divider so that both filter windows fit into a short run. Glitches are kept shorter than one strobe period, and accepted levels are held for more than three periods, so every outcome is decided by the rule and not by where the strobe happens to fall.

// File: rtl/ipcos_pkg.sv
// Package: shared widths and types of the change-of-state detector.
// Assumes the status byte layout is fixed: levels low nibble, flags high.
package ipcos_pkg;
    localparam int NPINS  = 3;
    localparam int STAT_W = 8;
    localparam int FLAG_LSB = 4;

    typedef logic [NPINS-1:0]  pinvec_t;
    typedef logic [STAT_W-1:0] stat_t;

    // Pack levels and flags into the CPU-visible byte; spare bits are zero.
    function automatic stat_t pack_status(pinvec_t lvl, pinvec_t flg);
        stat_t s;
        s = '0;
        s[NPINS-1:0]                = lvl;
        s[FLAG_LSB+NPINS-1:FLAG_LSB] = flg;
        return s;
    endfunction
endpackage

// File: rtl/ipcos_strobe.sv
// Module: free-running divider producing the filter sample strobe.
// Assumes DIV >= 2; one strobe cycle every DIV clock cycles.
module ipcos_strobe #(
    parameter int DIV = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
endmodule

// File: rtl/ipcos_startup.sv
// Module: holds the detector idle until START_TICKS serial-clock strobes
// have passed after reset, then issues a one-cycle load and stays running.
// Assumes ser_tick is a single-cycle strobe.
module ipcos_startup #(
    parameter int START_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_tick,
    output logic load_o,
    output logic run_o
);
    localparam int CNT_W = $clog2(START_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign load_o = ser_tick && !run_q && (cnt_q == LAST);
    assign run_o  = run_q;

    // Count serial strobes until the start point.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (ser_tick && !run_q) cnt_q <= cnt_q + 1'b1;
    end

    // Latch the running state at the start point.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (load_o) run_q <= 1'b1;
    end

    AST_START_ON_SER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(ser_tick)); // R4
    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> run_q); // R4
endmodule

// File: rtl/ipcos_chan.sv
// Module: one pin channel: two-flop synchronizer followed by a filter that
// accepts a differing level only on its second consecutive sample strobe.
// Assumes pin_i is asynchronous; load_i copies the synchronized pin directly.
module ipcos_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic tick_i,
    input  logic run_i,
    input  logic load_i,
    output logic sync_o,
    output logic level_o,
    output logic chg_o
);
    logic meta_q, sync_q, stable_q, cand_q;
    logic differ;

    assign differ  = (sync_q != stable_q);
    assign chg_o   = run_i && tick_i && differ && cand_q;
    assign sync_o  = sync_q;
    assign level_o = stable_q;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Track the filtered level and whether the last strobe saw a difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b1;
            cand_q   <= 1'b0;
        end else if (load_i) begin
            stable_q <= sync_q;
            cand_q   <= 1'b0;
        end else if (run_i && tick_i) begin
            if (chg_o) begin
                stable_q <= sync_q;
                cand_q   <= 1'b0;
            end else begin
                cand_q   <= differ;
            end
        end
    end

    AST_LEVEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stable_q) |-> ($past(tick_i) || $past(load_i))); // R2
    AST_CAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(stable_q) && !$past(load_i)) |-> $past(cand_q)); // R2
endmodule

// File: rtl/ipcos_monitor.sv
// Module: top of the input-port change-of-state detector. Holds the sticky
// flags, the write-only enables and the registered interrupt, and forms the
// status byte. Assumes rd_stb and wr_stb are single-cycle strobes.
module ipcos_monitor
    import ipcos_pkg::*;
#(
    parameter int              TICK_DIV    = 3125,
    parameter int              START_TICKS = 2,
    parameter logic [NPINS-1:0] CTS_MASK   = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_tick,
    input  logic [NPINS-1:0] pins_i,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [NPINS-1:0] wr_data,
    output logic [STAT_W-1:0] status_o,
    output logic             cos_any_o,
    output logic             irq_o
);
    logic    tick, load, run;
    pinvec_t sync_v, level_v, chg_v, set_v;
    pinvec_t flag_q, ien_q;
    logic    irq_q;

    ipcos_strobe #(.DIV(TICK_DIV)) u_strobe (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ipcos_startup #(.START_TICKS(START_TICKS)) u_start (
        .clk(clk), .rst_n(rst_n), .ser_tick(ser_tick),
        .load_o(load), .run_o(run)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_chan
        ipcos_chan u_chan (
            .clk(clk), .rst_n(rst_n), .pin_i(pins_i[i]),
            .tick_i(tick), .run_i(run), .load_i(load),
            .sync_o(sync_v[i]), .level_o(level_v[i]), .chg_o(chg_v[i])
        );
    end

    // Flag sources: filtered transitions plus handshake pins low at start.
    assign set_v = chg_v | (load ? (CTS_MASK & ~sync_v) : '0);

    // Sticky flags: a read clears, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_stb ? '0 : flag_q) | set_v;
    end

    // Write-only enable field.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_stb) ien_q <= wr_data;
    end

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & ien_q);
    end

    assign status_o  = pack_status(run ? level_v : '1, flag_q);
    assign cos_any_o = |flag_q;
    assign irq_o     = irq_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] == 1'b0) && (status_o[3] == 1'b0)); // R1
    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (flag_q == '0)); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && set_v == '0) |=> (flag_q == '0)); // R6
    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((flag_q & $past(set_v)) == $past(set_v))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ien_q) == '0) |=> !irq_o); // R8
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ien_q) != '0) |=> irq_o); // R8
endmodule

// File: tb/ipcos_monitor_test.sv
// Directed bench for the change-of-state detector.
module ipcos_monitor_test;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_tick = 1'b0;
    logic [2:0] pins = 3'b010;
    logic       rd = 1'b0, wr = 1'b0;
    logic [2:0] wdat = 3'b000;
    logic [7:0] status;
    logic       cos_any, irq;
    int         errors = 0, checks = 0;
    int         ser_cnt = 0;

    ipcos_monitor #(.TICK_DIV(DIV), .START_TICKS(2), .CTS_MASK(3'b011)) uut (
        .clk(clk), .rst_n(rst_n), .ser_tick(ser_tick), .pins_i(pins),
        .rd_stb(rd), .wr_stb(wr), .wr_data(wdat),
        .status_o(status), .cos_any_o(cos_any), .irq_o(irq)
    );

    always #4 clk = ~clk;

    // Serial-clock strobe every fourth cycle after reset.
    always @(negedge clk) begin
        if (!rst_n) begin
            ser_cnt  <= 0;
            ser_tick <= 1'b0;
        end else begin
            ser_cnt  <= ser_cnt + 1;
            ser_tick <= (ser_cnt % 4 == 3);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1'b1; cycles(1); rd = 1'b0; cycles(1);
    endtask

    task automatic do_write(input logic [2:0] v);
        wdat = v; wr = 1'b1; cycles(1); wr = 1'b0;
    endtask

    task automatic t_reset_and_start();
        cycles(4); rst_n = 1'b1; cycles(1);
        check("R4 pre-start status", status, 8'h07);
        check("R4 pre-start summary", cos_any, 0);
        check("R8 irq after reset", irq, 0);
        cycles(20);
        // pin0 low and CTS -> flag; pin2 low, not CTS -> none; R1 R9 layout
        check("R5 start-up CTS flag", status, 8'h12);
        check("R6 summary set", cos_any, 1);
        check("R8 enables reset to zero", irq, 0);
    endtask

    task automatic t_read_clear();
        do_read();
        check("R6 read clears flags", status, 8'h02);
        check("R6 summary clear", cos_any, 0);
    endtask

    task automatic t_rise_and_irq();
        pins[2] = 1'b1; cycles(3*DIV + 6);
        check("R3 R9 rising transition", status, 8'h46);
        do_write(3'b001); cycles(3);
        check("R8 unmatched enable", irq, 0);
        do_write(3'b100); cycles(3);
        check("R8 matched enable", irq, 1);
        do_read(); cycles(2);
        check("R8 irq drops after clear", irq, 0);
        check("R6 status after clear", status, 8'h06);
    endtask

    task automatic t_fall();
        pins[1] = 1'b0; cycles(3*DIV + 6);
        check("R3 falling transition", status, 8'h24);
        do_read();
    endtask

    task automatic t_glitch();
        pins[0] = 1'b1; cycles(DIV - 3); pins[0] = 1'b0;
        cycles(3*DIV + 6);
        check("R2 glitch ignored", status, 8'h04);
        check("R2 glitch summary", cos_any, 0);
    endtask

    task automatic t_collision();
        bit seen = 0;
        rd = 1'b1; pins[0] = 1'b1;
        for (int i = 0; i < 3*DIV + 6; i++) begin
            cycles(1);
            if (status[4]) seen = 1;
        end
        rd = 1'b0; cycles(1);
        check("R7 set beats same-cycle read", seen, 1);
        check("R1 R9 final status", status, 8'h05);
    endtask

    initial begin
        fork
            begin
                t_reset_and_start();
                t_read_clear();
                t_rise_and_irq();
                t_fall();
                t_glitch();
                t_collision();
            end
            begin
                cycles(5000);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule